// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block is the mode-control state machine of a CAN controller. It holds three software control bits: a sleep request, an initialization request and an automatic-wakeup enable. It tracks the receive line, and from these it keeps the controller in one of three operating modes: sleep, initialization or normal. It reports the current mode and two mutually exclusive status flags. It also drives a clock enable that gates the protocol engine.

Software loads all three control bits at once through a write strobe. The block leaves its reset state, sleep, in one of two ways. Software can clear the sleep request, or the block can react to a falling edge on the receive line while automatic wakeup is enabled; in that case hardware clears the sleep request itself. Every exit from sleep lands in initialization. The block moves on to normal only once the bus has been seen idle for a run of recessive bit samples.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the mode output is sleep (encoding 0 = sleep, 1 = initialization, 2 = normal). The sleep status flag is 1, the initialization status flag is 0, the engine clock enable is 0 and the sleep-request readback is 1.
- R2: The engine clock enable is 0 in every cycle the block is in sleep and 1 in initialization and normal.
- R3: A write with the sleep-request bit set moves the block from initialization or normal into sleep. The sleep status flag is then set.
- R4: In sleep, a write with the sleep-request bit clear and the initialization-request bit set moves the block to initialization.
- R5: In sleep, a write with both request bits clear also moves the block to initialization, never straight to normal.
- R6: In sleep with automatic wakeup enabled, a falling edge on the receive line (after a two-flop synchronizer) moves the block to initialization. Hardware clears the sleep-request readback.
- R7: In sleep with automatic wakeup disabled, receive-line activity has no effect: the mode stays sleep and the sleep-request readback stays 1.
- R8: Initialization moves to normal only when both request bits are clear and 11 consecutive bit samples (one every CYC_PER_BIT clocks) have been recessive (1). A dominant (0) sample restarts the count.
- R9: In normal, a write with the initialization-request bit set and the sleep-request bit clear moves the block to initialization.
- R10: The initialization status flag is 1 exactly while in initialization and the sleep status flag is 1 exactly while in sleep. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Write strobe for the three control bits |
| ctl_sleep_i | input | 1 | Sleep-request value to write |
| ctl_init_i | input | 1 | Initialization-request value to write |
| ctl_awu_i | input | 1 | Automatic-wakeup enable value to write |
| rx_i | input | 1 | Asynchronous receive line (1 = recessive) |
| mode_o | output | 2 | Current mode: 0 sleep, 1 initialization, 2 normal |
| sleep_sts_o | output | 1 | Sleep status flag |
| init_sts_o | output | 1 | Initialization status flag |
| eng_clk_en_o | output | 1 | Clock enable for the protocol engine |
| sleep_req_o | output | 1 | Readback of the held sleep-request bit |

## Verification
The bench drives the recessive-run qualifier hard. It checks that normal is not reached before the eleventh recessive sample. A counter that runs short, or that fails to restart on a dominant sample, would reach normal early, and the bench catches it while the block should still report initialization. On wakeup it checks that the sleep request is cleared by hardware, because a design that kept it set would fall straight back into sleep. It also checks that bus edges leave sleep untouched while wakeup is disabled, and that a software exit with both requests clear stops in initialization rather than jumping to normal.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_NORMAL = 2'd2
  } mode_e;

  // Clocks from the start of qualification to the count reaching its target.
  function automatic int unsigned idle_wait_cycles(input int unsigned cyc_per_bit,
                                                   input int unsigned bits);
    return cyc_per_bit * bits;
  endfunction

endpackage

// File: rtl/can_rx_edge.sv
module can_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_sync_o,
  output logic rx_fall_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= rx_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rx_sync_o = s2_q;
  assign rx_fall_o = prev_q & ~s2_q;
endmodule

// File: rtl/can_idle_qual.sv
module can_idle_qual #(
  parameter int unsigned CYC_PER_BIT = 4,
  parameter int unsigned IDLE_BITS   = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rx_sync_i,
  output logic done_o
);
  localparam int unsigned PW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam int unsigned CW = $clog2(IDLE_BITS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(IDLE_BITS);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          tick_w;

  assign tick_w = en_i && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!en_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick_w ? '0 : pre_q + 1'b1;
      if (tick_w) begin
        if (!rx_sync_i)            cnt_q <= '0;
        else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = en_i && (cnt_q == CNT_TOP);
endmodule

// File: rtl/can_ctl_bits.sv
module can_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic sleep_i,
  input  logic init_i,
  input  logic awu_i,
  input  logic wake_clr_i,
  output logic sleep_q_o,
  output logic init_q_o,
  output logic awu_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q_o <= 1'b1;
      init_q_o  <= 1'b0;
      awu_q_o   <= 1'b0;
    end else if (wr_i) begin
      sleep_q_o <= sleep_i;
      init_q_o  <= init_i;
      awu_q_o   <= awu_i;
    end else if (wake_clr_i) begin
      sleep_q_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int unsigned CYC_PER_BIT = 4,
  parameter int unsigned IDLE_BITS   = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr_i,
  input  logic       ctl_sleep_i,
  input  logic       ctl_init_i,
  input  logic       ctl_awu_i,
  input  logic       rx_i,
  output logic [1:0] mode_o,
  output logic       sleep_sts_o,
  output logic       init_sts_o,
  output logic       eng_clk_en_o,
  output logic       sleep_req_o
);
  mode_e mode_q, mode_d;
  logic  sleep_q, init_q, awu_q;
  logic  rx_sync_w, rx_fall_w;
  logic  wake_evt_w, idle_en_w, idle_done_w;

  can_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .rx_sync_o(rx_sync_w), .rx_fall_o(rx_fall_w)
  );

  can_ctl_bits u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr_i),
    .sleep_i(ctl_sleep_i), .init_i(ctl_init_i), .awu_i(ctl_awu_i),
    .wake_clr_i(wake_evt_w),
    .sleep_q_o(sleep_q), .init_q_o(init_q), .awu_q_o(awu_q)
  );

  assign wake_evt_w = (mode_q == MODE_SLEEP) && awu_q && rx_fall_w;
  assign idle_en_w  = (mode_q == MODE_INIT) && !sleep_q && !init_q;

  can_idle_qual #(.CYC_PER_BIT(CYC_PER_BIT), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .en_i(idle_en_w),
    .rx_sync_i(rx_sync_w), .done_o(idle_done_w)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SLEEP:  if (wake_evt_w || !sleep_q) mode_d = MODE_INIT;
      MODE_INIT:   if (sleep_q)                mode_d = MODE_SLEEP;
                   else if (idle_done_w)       mode_d = MODE_NORMAL;
      MODE_NORMAL: if (sleep_q)                mode_d = MODE_SLEEP;
                   else if (init_q)            mode_d = MODE_INIT;
      default:                                 mode_d = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SLEEP;
    else        mode_q <= mode_d;
  end

  assign mode_o       = mode_q;
  assign sleep_sts_o  = (mode_q == MODE_SLEEP);
  assign init_sts_o   = (mode_q == MODE_INIT);
  assign eng_clk_en_o = (mode_q != MODE_SLEEP);
  assign sleep_req_o  = sleep_q;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr_i,
  input logic [1:0] mode_o,
  input logic       sleep_sts_o,
  input logic       init_sts_o,
  input logic       eng_clk_en_o,
  input logic       sleep_req_o,
  input logic       wake_evt_w,
  input logic       idle_done_w,
  input logic       awu_q
);
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_sts_o && init_sts_o));

  p_no_clk_in_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_sts_o |-> !eng_clk_en_o);

  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req_o && mode_o != 2'd0 && !ctl_wr_i) |=> (mode_o == 2'd0));

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt_w && !ctl_wr_i) |=> (mode_o == 2'd1 && !sleep_req_o));

  p_stay_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && sleep_req_o && !awu_q && !ctl_wr_i) |=> (mode_o == 2'd0));

  p_normal_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && !idle_done_w) |=> (mode_o != 2'd2));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr_i), .mode_o(mode_o),
  .sleep_sts_o(sleep_sts_o), .init_sts_o(init_sts_o),
  .eng_clk_en_o(eng_clk_en_o), .sleep_req_o(sleep_req_o),
  .wake_evt_w(wake_evt_w), .idle_done_w(idle_done_w), .awu_q(awu_q)
);

// File: tb/sim_can_mode_seq.sv
`timescale 1ns/1ps
module sim_can_mode_seq;
  localparam int CPB  = 4;
  localparam int IDLE = 11;
  localparam int WAIT_NORMAL = CPB * IDLE; // clocks of recessive run needed

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, w_sleep = 1'b0, w_init = 1'b0, w_awu = 1'b0, rx = 1'b1;
  logic [1:0] mode;
  logic sleep_sts, init_sts, clk_en, sleep_req;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_seq #(.CYC_PER_BIT(CPB), .IDLE_BITS(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr_i(wr), .ctl_sleep_i(w_sleep),
    .ctl_init_i(w_init), .ctl_awu_i(w_awu), .rx_i(rx), .mode_o(mode),
    .sleep_sts_o(sleep_sts), .init_sts_o(init_sts),
    .eng_clk_en_o(clk_en), .sleep_req_o(sleep_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic s, input logic i, input logic a);
    @(negedge clk);
    wr = 1'b1; w_sleep = s; w_init = i; w_awu = a;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic chk_mode(input string req, input int exp);
    chk(req, "mode", mode, exp);
    chk("R10", "sleep flag", sleep_sts, exp == 0);
    chk("R10", "init flag", init_sts, exp == 1);
    chk("R2", "clock enable", clk_en, exp != 0);
  endtask

  task automatic t_reset;
    chk_mode("R1", 0);
    chk("R1", "sleep req readback", sleep_req, 1);
  endtask

  task automatic t_no_wake_when_disabled;
    rx = 1'b0; cyc(6); rx = 1'b1; cyc(6);
    chk_mode("R7", 0);
    chk("R7", "sleep req readback", sleep_req, 1);
  endtask

  task automatic t_sleep_to_init;
    write_ctl(1'b0, 1'b1, 1'b0);
    cyc(2);
    chk_mode("R4", 1);
  endtask

  task automatic t_init_to_normal_with_restart;
    write_ctl(1'b0, 1'b0, 1'b0);
    cyc(20);
    rx = 1'b0; cyc(6); rx = 1'b1;
    cyc(30); // 56 clocks since release, beyond one uninterrupted run
    chk_mode("R8", 1);
    cyc(30);
    chk_mode("R8", 2);
  endtask

  task automatic t_normal_to_init;
    write_ctl(1'b0, 1'b1, 1'b0);
    cyc(2);
    chk_mode("R9", 1);
  endtask

  task automatic t_exact_run;
    write_ctl(1'b0, 1'b0, 1'b0);
    cyc(WAIT_NORMAL - 6);
    chk_mode("R8", 1);
    cyc(10);
    chk_mode("R8", 2);
  endtask

  task automatic t_to_sleep;
    write_ctl(1'b1, 1'b0, 1'b0);
    cyc(2);
    chk_mode("R3", 0);
  endtask

  task automatic t_sw_exit_both_clear;
    write_ctl(1'b0, 1'b0, 1'b0);
    cyc(2);
    chk_mode("R5", 1);
    cyc(WAIT_NORMAL + 8);
    chk_mode("R8", 2);
  endtask

  task automatic t_autowake;
    write_ctl(1'b1, 1'b0, 1'b1);
    cyc(2);
    chk_mode("R3", 0);
    rx = 1'b0; cyc(5); rx = 1'b1;
    chk_mode("R6", 1);
    chk("R6", "sleep req cleared", sleep_req, 0);
    cyc(WAIT_NORMAL + 10);
    chk_mode("R6", 2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_no_wake_when_disabled();
    t_sleep_to_init();
    t_init_to_normal_with_restart();
    t_normal_to_init();
    t_exact_run();
    t_to_sleep();
    t_sw_exit_both_clear();
    t_to_sleep();
    t_autowake();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule